// File: doc/BRIEF.md
# Segmented Memory Bus Access Unit

This unit sits between a requester that thinks in segment and offset terms and a 16-bit memory bus organised as two byte lanes. It forms a 20-bit byte address by placing the segment four bit positions up and adding the offset. It then performs one byte or one word transfer, reading or writing, and reports completion with a single-cycle done pulse.

Bytes at even addresses travel on the low lane and bytes at odd addresses on the high lane. A word at an even address moves in a single bus cycle with both lanes enabled. A word at an odd address is split into two bus cycles. On reads its two bytes are put back in little-endian order before done is raised. Each bus cycle waits for the memory's ready handshake, so any number of wait cycles is tolerated.

Top module: `seg_bus_unit`

## Requirements
- R1: The bus address of the first cycle equals (segment * 16 + offset) modulo 2^20; for example segment 6020h with offset 4267h gives 64467h, and segment FFFFh with offset 0010h gives 00000h.
- R2: A byte access drives byte enable 01 with data on bits 7..0 at an even address, and enable 10 with data on bits 15..8 at an odd address. A byte write takes its data from write data bits 7..0, and the unused lane is driven with zero. A byte read returns the byte in read data bits 7..0 with bits 15..8 zero.
- R3: A word at an even address completes in exactly one bus cycle, with enable 11 and write data passed unchanged.
- R4: A word at an odd address A takes exactly two bus cycles. The first is at A with enable 10. The second is at (A+1) modulo 2^20 with enable 01. No other bus cycle is issued for the request.
- R5: Words are little-endian. For an odd-address word write, the first cycle carries write bits 7..0 on lane bits 15..8, and the second carries write bits 15..8 on lane bits 7..0. An odd-address word read returns {byte at A+1, byte at A}.
- R6: While the strobe is high and ready is low, the address, byte enables, write data and write flag stay unchanged into the next cycle.
- R7: Done is high for exactly one clock, in the cycle after the final ready handshake, and read data is valid in that cycle.
- R8: Busy is high from the cycle after an accepted start until the final handshake. A start seen while busy is ignored and causes no bus cycle.
- R9: After reset, strobe, busy and done are low and read data is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_start_i | input | 1 | Start strobe for one access |
| req_seg_i | input | 16 | Segment value |
| req_off_i | input | 16 | Offset within the segment |
| req_word_i | input | 1 | 1 = word access, 0 = byte access |
| req_write_i | input | 1 | 1 = write, 0 = read |
| req_wdata_i | input | 16 | Write data (byte writes use bits 7..0) |
| req_rdata_o | output | 16 | Read data, valid with done |
| req_done_o | output | 1 | One-cycle completion pulse |
| busy_o | output | 1 | Access in progress |
| mem_addr_o | output | 20 | Byte address of the current bus cycle |
| mem_be_o | output | 2 | Byte-lane enables, bit 0 = bits 7..0 |
| mem_wdata_o | output | 16 | Lane-steered write data |
| mem_write_o | output | 1 | Direction of the current bus cycle |
| mem_strobe_o | output | 1 | Bus cycle request |
| mem_rdata_i | input | 16 | Read data from memory, valid with ready |
| mem_ready_i | input | 1 | Memory accepts or completes the current cycle |

## Verification
The properties assume that memory raises ready only while the strobe is high, and that request fields are meaningful only in the cycle start is high. The bench's memory responder answers only to an active strobe. It drops ready right after each handshake and inserts 0 to 3 wait cycles per bus cycle. The driver scrambles the request fields once start is released, so any use of unlatched inputs shows up as a wrong address or wrong data.

// File: rtl/seg_bus_pkg.sv
`timescale 1ns/1ps
package seg_bus_pkg;
  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_FIRST  = 2'd1,
    ST_SECOND = 2'd2
  } bus_state_e;
endpackage

// File: rtl/seg_addr_gen.sv
`timescale 1ns/1ps
module seg_addr_gen #(
  parameter int SEG_W = 16,
  parameter int OFF_W = 16,
  parameter int SHIFT = 4,
  localparam int ADDR_W = SEG_W + SHIFT
) (
  input  logic [SEG_W-1:0]  seg_i,
  input  logic [OFF_W-1:0]  off_i,
  output logic [ADDR_W-1:0] phys_o
);
  logic [ADDR_W-1:0] seg_ext;
  logic [ADDR_W-1:0] off_ext;

  assign seg_ext = {seg_i, {SHIFT{1'b0}}};
  assign off_ext = {{(ADDR_W-OFF_W){1'b0}}, off_i};
  // truncation to ADDR_W bits gives the modulo wrap
  assign phys_o  = seg_ext + off_ext;
endmodule

// File: rtl/seg_lane_plan.sv
`timescale 1ns/1ps
module seg_lane_plan #(
  parameter int LANE_W = 8,
  localparam int DATA_W = 2 * LANE_W
) (
  input  logic              odd_i,
  input  logic              word_i,
  input  logic              second_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [1:0]        be_o,
  output logic [DATA_W-1:0] wdata_o
);
  logic [LANE_W-1:0] lo_b;
  logic [LANE_W-1:0] hi_b;
  logic [LANE_W-1:0] zero_b;

  assign lo_b   = wdata_i[LANE_W-1:0];
  assign hi_b   = wdata_i[DATA_W-1:LANE_W];
  assign zero_b = {LANE_W{1'b0}};

  always_comb begin
    if (!word_i) begin
      be_o    = odd_i ? 2'b10 : 2'b01;
      wdata_o = odd_i ? {lo_b, zero_b} : {zero_b, lo_b};
    end else if (!odd_i) begin
      be_o    = 2'b11;
      wdata_o = wdata_i;
    end else if (!second_i) begin
      // split word, low byte first on upper lane
      be_o    = 2'b10;
      wdata_o = {lo_b, zero_b};
    end else begin
      be_o    = 2'b01;
      wdata_o = {zero_b, hi_b};
    end
  end
endmodule

// File: rtl/seg_bus_ctrl.sv
`timescale 1ns/1ps
module seg_bus_ctrl
  import seg_bus_pkg::*;
#(
  parameter int ADDR_W = 20,
  parameter int DATA_W = 16,
  localparam int LANE_W = DATA_W / 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [ADDR_W-1:0] phys_i,
  input  logic              word_i,
  input  logic              write_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [DATA_W-1:0] mem_rdata_i,
  input  logic              mem_ready_i,
  output logic              strobe_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic              odd_o,
  output logic              second_o,
  output logic              word_o,
  output logic              write_o,
  output logic [DATA_W-1:0] wdata_o,
  output logic [DATA_W-1:0] rdata_o,
  output logic              done_o,
  output logic              busy_o
);
  bus_state_e        state_q;
  logic [ADDR_W-1:0] phys_q;
  logic              word_q;
  logic              write_q;
  logic [DATA_W-1:0] wdata_q;
  logic [LANE_W-1:0] lo_q;
  logic [DATA_W-1:0] rdata_q;
  logic              done_q;
  logic              split;
  logic [DATA_W-1:0] first_rdata;

  assign split = word_q & phys_q[0];

  always_comb begin
    if (word_q)         first_rdata = mem_rdata_i;
    else if (phys_q[0]) first_rdata = {{LANE_W{1'b0}}, mem_rdata_i[DATA_W-1:LANE_W]};
    else                first_rdata = {{LANE_W{1'b0}}, mem_rdata_i[LANE_W-1:0]};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      phys_q  <= '0;
      word_q  <= 1'b0;
      write_q <= 1'b0;
      wdata_q <= '0;
      lo_q    <= '0;
      rdata_q <= '0;
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      case (state_q)
        ST_IDLE: begin
          if (start_i) begin
            phys_q  <= phys_i;
            word_q  <= word_i;
            write_q <= write_i;
            wdata_q <= wdata_i;
            state_q <= ST_FIRST;
          end
        end
        ST_FIRST: begin
          if (mem_ready_i) begin
            if (split) begin
              lo_q    <= mem_rdata_i[DATA_W-1:LANE_W];
              state_q <= ST_SECOND;
            end else begin
              rdata_q <= first_rdata;
              done_q  <= 1'b1;
              state_q <= ST_IDLE;
            end
          end
        end
        ST_SECOND: begin
          if (mem_ready_i) begin
            rdata_q <= {mem_rdata_i[LANE_W-1:0], lo_q};
            done_q  <= 1'b1;
            state_q <= ST_IDLE;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign strobe_o = (state_q != ST_IDLE);
  assign busy_o   = (state_q != ST_IDLE);
  assign second_o = (state_q == ST_SECOND);
  assign addr_o   = second_o ? phys_q + ADDR_W'(1) : phys_q;
  assign odd_o    = phys_q[0];
  assign word_o   = word_q;
  assign write_o  = write_q;
  assign wdata_o  = wdata_q;
  assign rdata_o  = rdata_q;
  assign done_o   = done_q;
endmodule

// File: rtl/seg_bus_unit.sv
`timescale 1ns/1ps
module seg_bus_unit #(
  parameter int SEG_W  = 16,
  parameter int OFF_W  = 16,
  parameter int SHIFT  = 4,
  parameter int DATA_W = 16,
  localparam int ADDR_W = SEG_W + SHIFT,
  localparam int LANE_W = DATA_W / 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_start_i,
  input  logic [SEG_W-1:0]  req_seg_i,
  input  logic [OFF_W-1:0]  req_off_i,
  input  logic              req_word_i,
  input  logic              req_write_i,
  input  logic [DATA_W-1:0] req_wdata_i,
  output logic [DATA_W-1:0] req_rdata_o,
  output logic              req_done_o,
  output logic              busy_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [1:0]        mem_be_o,
  output logic [DATA_W-1:0] mem_wdata_o,
  output logic              mem_write_o,
  output logic              mem_strobe_o,
  input  logic [DATA_W-1:0] mem_rdata_i,
  input  logic              mem_ready_i
);
  logic [ADDR_W-1:0] phys;
  logic              odd_q;
  logic              second;
  logic              word_q;
  logic [DATA_W-1:0] wdata_q;

  seg_addr_gen #(
    .SEG_W(SEG_W),
    .OFF_W(OFF_W),
    .SHIFT(SHIFT)
  ) u_addr (
    .seg_i (req_seg_i),
    .off_i (req_off_i),
    .phys_o(phys)
  );

  seg_bus_ctrl #(
    .ADDR_W(ADDR_W),
    .DATA_W(DATA_W)
  ) u_ctrl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .start_i    (req_start_i),
    .phys_i     (phys),
    .word_i     (req_word_i),
    .write_i    (req_write_i),
    .wdata_i    (req_wdata_i),
    .mem_rdata_i(mem_rdata_i),
    .mem_ready_i(mem_ready_i),
    .strobe_o   (mem_strobe_o),
    .addr_o     (mem_addr_o),
    .odd_o      (odd_q),
    .second_o   (second),
    .word_o     (word_q),
    .write_o    (mem_write_o),
    .wdata_o    (wdata_q),
    .rdata_o    (req_rdata_o),
    .done_o     (req_done_o),
    .busy_o     (busy_o)
  );

  seg_lane_plan #(
    .LANE_W(LANE_W)
  ) u_lane (
    .odd_i   (odd_q),
    .word_i  (word_q),
    .second_i(second),
    .wdata_i (wdata_q),
    .be_o    (mem_be_o),
    .wdata_o (mem_wdata_o)
  );
endmodule

// File: rtl/seg_bus_unit_chk.sv
`timescale 1ns/1ps
module seg_bus_unit_chk #(
  parameter int SEG_W  = 16,
  parameter int OFF_W  = 16,
  parameter int SHIFT  = 4,
  parameter int DATA_W = 16,
  localparam int ADDR_W = SEG_W + SHIFT
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              req_start_i,
  input logic [SEG_W-1:0]  req_seg_i,
  input logic [OFF_W-1:0]  req_off_i,
  input logic              req_done_o,
  input logic              busy_o,
  input logic [ADDR_W-1:0] mem_addr_o,
  input logic [1:0]        mem_be_o,
  input logic [DATA_W-1:0] mem_wdata_o,
  input logic              mem_write_o,
  input logic              mem_strobe_o,
  input logic              mem_ready_i
);
  a_r1_first_addr: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(mem_strobe_o) |-> mem_addr_o ==
      ({$past(req_seg_i), {SHIFT{1'b0}}} + {{(ADDR_W-OFF_W){1'b0}}, $past(req_off_i)}));

  a_r2_lane_parity: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_strobe_o |-> (mem_be_o != 2'b00) && ((mem_be_o == 2'b10) == mem_addr_o[0]));

  a_r6_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_strobe_o && !mem_ready_i |=> mem_strobe_o && $stable(mem_addr_o) &&
      $stable(mem_be_o) && $stable(mem_wdata_o) && $stable(mem_write_o));

  a_r7_single_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_done_o |=> !req_done_o);

  a_r7_done_follows_ready: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(req_done_o) |-> $past(mem_strobe_o && mem_ready_i));

  a_r8_busy_needs_start: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> $past(req_start_i));
endmodule

bind seg_bus_unit seg_bus_unit_chk #(
  .SEG_W(SEG_W),
  .OFF_W(OFF_W),
  .SHIFT(SHIFT),
  .DATA_W(DATA_W)
) u_chk (.*);

// File: tb/seg_bus_unit_tb.sv
`timescale 1ns/1ps
module seg_bus_unit_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [15:0] seg = '0;
  logic [15:0] off = '0;
  logic        word = 1'b0;
  logic        wr = 1'b0;
  logic [15:0] wdata = '0;
  logic [15:0] rdata;
  logic        done;
  logic        busy;
  logic [19:0] maddr;
  logic [1:0]  mbe;
  logic [15:0] mwdata;
  logic        mwrite;
  logic        mstrobe;
  logic [15:0] mrdata = '0;
  logic        mready = 1'b0;

  always #2.5 clk = ~clk;

  seg_bus_unit u_dut (
    .clk_i(clk), .rst_ni(rst_n), .req_start_i(start), .req_seg_i(seg),
    .req_off_i(off), .req_word_i(word), .req_write_i(wr), .req_wdata_i(wdata),
    .req_rdata_o(rdata), .req_done_o(done), .busy_o(busy), .mem_addr_o(maddr),
    .mem_be_o(mbe), .mem_wdata_o(mwdata), .mem_write_o(mwrite),
    .mem_strobe_o(mstrobe), .mem_rdata_i(mrdata), .mem_ready_i(mready)
  );

  typedef struct packed {
    logic [19:0] addr;
    logic [1:0]  be;
    logic [15:0] wd;
    logic        write;
  } cyc_t;

  cyc_t        exp_cyc[$];
  string       exp_tag[$];
  logic [15:0] exp_rd[$];
  logic        exp_isrd[$];
  string       rd_tag[$];
  logic [7:0]  store[logic [19:0]];
  int n_chk = 0;
  int n_err = 0;
  int wait_cfg = 0;
  int wcnt = 0;

  function automatic logic [7:0] rd_byte(input logic [19:0] a);
    if (store.exists(a)) return store[a];
    return a[7:0] ^ a[15:8] ^ {4'h0, a[19:16]} ^ 8'h5A;
  endfunction

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // monitor: bus cycles at handshake
  always @(posedge clk) begin
    if (rst_n && mstrobe && mready) begin
      if (exp_cyc.size() == 0) begin
        check(1'b0, "R4 unexpected bus cycle", {12'h0, maddr}, 32'h0);
      end else begin
        cyc_t  e;
        string t;
        e = exp_cyc.pop_front();
        t = exp_tag.pop_front();
        check(maddr == e.addr, {t, " address"}, {12'h0, maddr}, {12'h0, e.addr});
        check(mbe == e.be, {t, " enables"}, {30'h0, mbe}, {30'h0, e.be});
        check(mwrite == e.write, {t, " direction"}, {31'h0, mwrite}, {31'h0, e.write});
        if (e.write) check(mwdata == e.wd, {t, " write lanes"}, {16'h0, mwdata}, {16'h0, e.wd});
        if (mwrite) begin
          if (mbe[0]) store[{maddr[19:1], 1'b0}] = mwdata[7:0];
          if (mbe[1]) store[{maddr[19:1], 1'b1}] = mwdata[15:8];
        end
      end
    end
  end

  // monitor for done/hold plus memory responder
  logic        hold_armed = 1'b0;
  logic [19:0] h_addr;
  logic [1:0]  h_be;
  logic [15:0] h_wd;
  logic        prev_done = 1'b0;

  always @(negedge clk) begin
    if (rst_n) begin
      if (hold_armed)
        check(mstrobe && maddr == h_addr && mbe == h_be && mwdata == h_wd,
              "R6 hold while not ready", {12'h0, maddr}, {12'h0, h_addr});
      if (prev_done && done) check(1'b0, "R7 done longer than one clock", 32'h1, 32'h0);
      if (done && !prev_done) begin
        check(exp_cyc.size() == 0, "R4 bus cycles missing at done", exp_cyc.size(), 32'h0);
        if (exp_rd.size() == 0) begin
          check(1'b0, "R7 done without request", 32'h1, 32'h0);
        end else begin
          logic [15:0] v;
          logic        isr;
          string       t;
          v = exp_rd.pop_front();
          isr = exp_isrd.pop_front();
          t = rd_tag.pop_front();
          if (isr) check(rdata == v, {t, " read data"}, {16'h0, rdata}, {16'h0, v});
        end
      end
    end
    prev_done = done;
    if (mready) begin
      mready = 1'b0;
      wcnt = wait_cfg;
    end else if (!mstrobe) begin
      wcnt = wait_cfg;
    end else if (wcnt == 0) begin
      mready = 1'b1;
      mrdata = {rd_byte({maddr[19:1], 1'b1}), rd_byte({maddr[19:1], 1'b0})};
    end else begin
      wcnt--;
    end
    hold_armed = rst_n && mstrobe && !mready;
    h_addr = maddr;
    h_be = mbe;
    h_wd = mwdata;
  end

  task automatic push_cyc(input logic [19:0] a, input logic [1:0] be, input logic [15:0] wd,
                          input logic w, input string t);
    cyc_t c;
    c.addr = a; c.be = be; c.wd = wd; c.write = w;
    exp_cyc.push_back(c);
    exp_tag.push_back(t);
  endtask

  task automatic access(input logic [15:0] s, input logic [15:0] o, input logic wd_sel,
                        input logic w, input logic [15:0] d, input bit poke, input string t);
    logic [19:0] p;
    logic [19:0] p1;
    p = {s, 4'h0} + {4'h0, o};
    p1 = p + 20'd1;
    if (!wd_sel) begin
      push_cyc(p, p[0] ? 2'b10 : 2'b01, p[0] ? {d[7:0], 8'h00} : {8'h00, d[7:0]}, w, {t, " R2"});
      exp_rd.push_back({8'h00, rd_byte(p)});
    end else if (!p[0]) begin
      push_cyc(p, 2'b11, d, w, {t, " R3"});
      exp_rd.push_back({rd_byte(p1), rd_byte(p)});
    end else begin
      push_cyc(p, 2'b10, {d[7:0], 8'h00}, w, {t, " R4 first"});
      push_cyc(p1, 2'b01, {8'h00, d[15:8]}, w, {t, " R5 second"});
      exp_rd.push_back({rd_byte(p1), rd_byte(p)});
    end
    exp_isrd.push_back(!w);
    rd_tag.push_back({t, " R5"});
    @(negedge clk);
    start = 1'b1; seg = s; off = o; word = wd_sel; wr = w; wdata = d;
    @(negedge clk);
    start = 1'b0; seg = ~s; off = ~o; word = ~wd_sel; wr = ~w; wdata = ~d;
    if (poke) begin
      check(busy == 1'b1, "R8 busy during access", {31'h0, busy}, 32'h1);
      start = 1'b1; seg = 16'h0123; off = 16'h0005; word = 1'b1; wr = 1'b1;
      @(negedge clk);
      start = 1'b0;
    end
    while (!done) @(negedge clk);
    @(negedge clk);
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    n_err++;
    n_chk++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_err);
    $finish;
  end

  initial begin : main
    repeat (3) @(negedge clk);
    check(!mstrobe && !busy && !done && rdata == 16'h0, "R9 reset state",
          {mstrobe, busy, done, 13'h0, rdata}, 32'h0);
    rst_n = 1'b1;
    @(negedge clk);
    check(!mstrobe && !busy, "R9 idle after reset", {30'h0, mstrobe, busy}, 32'h0);

    wait_cfg = 0;
    access(16'h6020, 16'h4267, 1'b0, 1'b0, 16'h0, 1'b0, "R1 example odd byte read");
    access(16'h1000, 16'h0002, 1'b0, 1'b0, 16'h0, 1'b0, "R2 even byte read");
    access(16'h1000, 16'h0007, 1'b0, 1'b1, 16'hC3A5, 1'b0, "R2 odd byte write");
    access(16'h1000, 16'h0006, 1'b0, 1'b1, 16'h7E11, 1'b0, "R2 even byte write");
    access(16'h1000, 16'h0006, 1'b1, 1'b0, 16'h0, 1'b0, "R2 word readback of bytes");
    access(16'h2000, 16'h0010, 1'b1, 1'b1, 16'hBEEF, 1'b0, "R3 even word write");
    access(16'h2000, 16'h0010, 1'b1, 1'b0, 16'h0, 1'b0, "R3 even word read");
    access(16'h2000, 16'h0021, 1'b1, 1'b1, 16'h1234, 1'b0, "R5 odd word write");
    access(16'h2000, 16'h0021, 1'b1, 1'b0, 16'h0, 1'b0, "R5 odd word read");
    access(16'h2000, 16'h0021, 1'b0, 1'b0, 16'h0, 1'b0, "R5 low byte at A");
    access(16'h2000, 16'h0022, 1'b0, 1'b0, 16'h0, 1'b0, "R5 high byte at A+1");
    access(16'hFFFF, 16'h0010, 1'b0, 1'b0, 16'h0, 1'b0, "R1 wrap to zero");
    access(16'hFFFF, 16'h000F, 1'b1, 1'b1, 16'hA55A, 1'b0, "R4 odd word across wrap");
    access(16'hFFFF, 16'h000F, 1'b1, 1'b0, 16'h0, 1'b0, "R4 odd word read across wrap");

    wait_cfg = 3;
    access(16'h3000, 16'h0005, 1'b1, 1'b0, 16'h0, 1'b0, "R6 odd word read with waits");
    access(16'h3000, 16'h0009, 1'b1, 1'b1, 16'h5AA5, 1'b0, "R6 odd word write with waits");

    wait_cfg = 0;
    access(16'h4000, 16'h0100, 1'b1, 1'b0, 16'h0, 1'b1, "R8 start ignored while busy");
    wait_cfg = 2;
    access(16'h4000, 16'h0101, 1'b1, 1'b1, 16'h9876, 1'b1, "R8 start ignored, split write");
    access(16'h4000, 16'h0101, 1'b1, 1'b0, 16'h0, 1'b0, "R8 readback after ignored start");

    for (int i = 0; i < 12; i++) begin
      wait_cfg = i % 4;
      access(16'h5000 + 16'(i * 37), 16'(i * 13), i[0], i[1], 16'(16'h1357 * (i + 1)),
             1'b0, "R7 mixed sequence");
    end

    repeat (4) @(negedge clk);
    check(!busy && !mstrobe && exp_cyc.size() == 0, "R8 idle at end",
          {30'h0, busy, mstrobe}, 32'h0);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_err);
    $finish;
  end
endmodule